// File: doc/BRIEF.md
# Bus-Activity Power-Down Controller

This block decides when the memory and logic of a bus-attached peripheral may rest. It watches three things: the active-low chip select, the address-latch strobe, and a vector of logic-array inputs. If the host never deselects the part, the block still powers it down once the address-latch strobe has shown no edge for a programmed number of counter ticks. The counter ticks on every system clock, or on the rising edges of a slow alternate clock pin after synchronisation. The standby indication given to the logic array is the chip select combined with this power-down output.

A second state machine drives a zero-power enable for the logic array. It watches the input vector. Once the inputs have held still for a parameterised number of clock cycles, it lets the array drop into idle, and it wakes the array as soon as an input changes. A turbo configuration bit keeps the array out of idle. Two further configuration bits separately turn off the clock enables for the logic array and for its registered cells.

Software reaches the configuration through a small register port with two registers. One holds the mode bits. The other holds the inactivity limit.

Top module: `bus_idle_pdn`

State machines and transitions. The expiry machine has three states. `APD_OFF` is automatic power-down disabled. `APD_COUNT` is counting inactivity. `APD_DOWN` is power-down asserted. Its transitions are:
- arm: `APD_OFF` to `APD_COUNT`, when the enable is seen and the counter loads the limit.
- reload: `APD_COUNT` to `APD_COUNT`, on a strobe edge.
- tick: `APD_COUNT` to `APD_COUNT`, the counter decrements.
- expire: `APD_COUNT` to `APD_DOWN`, on a tick with the counter at 1 or below.
- wake: `APD_DOWN` to `APD_COUNT`, on a strobe edge, with a reload.
- disable: any state to `APD_OFF`, when the enable is clear.

The idle machine has two states, `ZP_BUSY` and `ZP_IDLE`. Its transitions are:
- settle: `ZP_BUSY` to `ZP_IDLE`, when the quiet counter reaches its last value.
- stir: any state to `ZP_BUSY`, on a detected input change or with turbo set.

## Requirements
- R1: `standby` is high in the same cycle whenever `cs_n` is high or `pdn` is high, and low otherwise.
- R2: Each rising clock edge at which `strobe` differs from its value at the previous rising edge reloads the inactivity counter with the limit register. With the system clock selected, one tick occurs per cycle, and `pdn` rises at the L-th rising edge after the reloading edge if no further strobe edge arrives (L = limit). A limit of 0 behaves as 1.
- R3: While mode bit 0 (auto power-down enable) is clear, `pdn` is low from the second rising edge after the write onward. Setting the bit again restarts counting from the limit: `pdn` rises at the (L+2)-th rising edge counted from the write edge, provided there is no strobe edge.
- R4: In power-down, a strobe edge sampled at a rising edge clears `pdn` at that same edge.
- R5: When a strobe edge is sampled at the same edge as the expiring tick, the edge wins. `pdn` stays low, and the next expiry is counted from that edge.
- R6: With mode bit 1 (alternate tick source) set, the counter advances only once per rising edge of `alt_clk`, after a SYNC-stage synchroniser. With `alt_clk` static the counter is frozen and `pdn` never rises.
- R7: With mode bit 4 (turbo) set, `zp_en` is low. With turbo clear, `zp_en` falls at the second rising edge after a change of `sense` is first sampled. It rises at the (IDLE_CYC+2)-th rising edge after that change if `sense` holds still.
- R8: Mode bit 2 set drives `array_clk_en` low. Mode bit 3 set drives `macro_clk_en` low. Each is independent of the other and is high when its bit is clear.
- R9: Register address 0 is the mode register, bits 4..0, with bits above 4 reading 0. Address 1 is the limit register. A write with `reg_wr` high takes effect at the rising edge. `reg_rdata` combinationally shows the register selected by `reg_addr`. Reset values are 0x10 for mode and DEF_LIMIT for the limit.
- R10: After reset, `pdn` and `zp_en` are low and both clock enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select; high forces standby |
| strobe | input | 1 | Address-latch strobe whose edges mark bus activity |
| alt_clk | input | 1 | Optional slow tick source for the inactivity counter |
| sense | input | IN_W | Logic-array inputs watched for change |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 mode, 1 limit |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Selected register contents |
| pdn | output | 1 | Automatic power-down indication |
| standby | output | 1 | Deselect to the logic array (chip select or power-down) |
| zp_en | output | 1 | Zero-power idle enable for the logic array |
| array_clk_en | output | 1 | Clock enable for the logic array |
| macro_clk_en | output | 1 | Clock enable for the registered cells |

## Verification
A strobe edge and the expiring counter tick can land on the same rising edge, and the block must then let the edge win. The bench provokes this deliberately: it reloads the counter and then toggles the strobe exactly L cycles later. Random strobe toggling against a short limit also produces many such collisions. Each cycle's `pdn` is judged against a bench model written from R2, R4 and R5, which makes the expected expiry restart from the colliding edge.

// File: rtl/bip_pkg.sv
package bip_pkg;

    typedef enum logic [1:0] {
        APD_OFF   = 2'd0,
        APD_COUNT = 2'd1,
        APD_DOWN  = 2'd2
    } apd_state_e;

    typedef enum logic {
        ZP_BUSY = 1'b0,
        ZP_IDLE = 1'b1
    } zp_state_e;

    // bit 4 turbo, bit 3 registered-cell clock off, bit 2 array clock off,
    // bit 1 alternate tick source, bit 0 auto power-down enable
    typedef struct packed {
        logic turbo;
        logic macro_off;
        logic array_off;
        logic alt_sel;
        logic apd_en;
    } mode_t;

    localparam int    MODE_W     = $bits(mode_t);
    localparam mode_t MODE_RESET = '{turbo: 1'b1, default: 1'b0};

    localparam logic REG_MODE  = 1'b0;
    localparam logic REG_LIMIT = 1'b1;

endpackage

// File: rtl/bip_regs.sv
module bip_regs
    import bip_pkg::*;
#(
    parameter int DW        = 8,
    parameter int CNT_W     = 8,
    parameter int DEF_LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    output mode_t            mode,
    output logic [CNT_W-1:0] limit,
    output logic [DW-1:0]    rdata
);

    localparam logic [CNT_W-1:0] LIMIT_RESET = CNT_W'(DEF_LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode  <= MODE_RESET;
            limit <= LIMIT_RESET;
        end else if (wr_en) begin
            if (addr == REG_MODE) begin
                mode <= mode_t'(wdata[MODE_W-1:0]);
            end else begin
                limit <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == REG_MODE) begin
            rdata[MODE_W-1:0] = mode;
        end else begin
            rdata[CNT_W-1:0] = limit;
        end
    end

endmodule

// File: rtl/bip_tick.sv
module bip_tick #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alt_clk,
    input  logic alt_sel,
    output logic tick
);

    logic [SYNC-1:0] sync_q;
    logic            last_q;

    for (genvar g = 0; g < SYNC; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= alt_clk;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC-1];
    end

    // system clock: one tick per cycle; alternate: one per synchronised rise
    always_comb begin
        if (alt_sel) tick = sync_q[SYNC-1] & ~last_q;
        else         tick = 1'b1;
    end

endmodule

// File: rtl/bip_apd.sv
module bip_apd
    import bip_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apd_en,
    input  logic [CNT_W-1:0] limit,
    input  logic             strobe,
    input  logic             tick,
    output logic             pdn
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    apd_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] reload;
    logic             strobe_q;
    logic             strobe_edge;

    assign strobe_edge = strobe ^ strobe_q;
    assign reload      = (limit == '0) ? ONE : limit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= APD_OFF;
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            strobe_q <= strobe;
        end
    end

    // transitions: arm, reload, tick, expire, wake, disable
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!apd_en) begin
            state_d = APD_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                APD_OFF: begin
                    state_d = APD_COUNT;
                    cnt_d   = reload;
                end
                APD_COUNT: begin
                    if (strobe_edge) begin
                        cnt_d = reload;
                    end else if (tick) begin
                        if (cnt_q <= ONE) state_d = APD_DOWN;
                        else              cnt_d   = cnt_q - ONE;
                    end
                end
                APD_DOWN: begin
                    if (strobe_edge) begin
                        state_d = APD_COUNT;
                        cnt_d   = reload;
                    end
                end
                default: begin
                    state_d = APD_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        pdn = (state_q == APD_DOWN);
    end

endmodule

// File: rtl/bip_idle.sv
module bip_idle
    import bip_pkg::*;
#(
    parameter int IN_W     = 16,
    parameter int IDLE_CYC = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            turbo,
    input  logic [IN_W-1:0] sense,
    output logic            zp_en
);

    localparam int            IC_W    = (IDLE_CYC > 1) ? $clog2(IDLE_CYC) : 1;
    localparam logic [IC_W-1:0] IC_LAST = IC_W'(IDLE_CYC - 1);

    logic [IN_W-1:0] in_q, in_prev;
    logic            changed;
    zp_state_e       st_q, st_d;
    logic [IC_W-1:0] ic_q, ic_d;

    assign changed = |(in_q ^ in_prev);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q    <= '0;
            in_prev <= '0;
            st_q    <= ZP_BUSY;
            ic_q    <= '0;
        end else begin
            in_q    <= sense;
            in_prev <= in_q;
            st_q    <= st_d;
            ic_q    <= ic_d;
        end
    end

    // transitions: settle, stir
    always_comb begin
        st_d = st_q;
        ic_d = ic_q;
        if (turbo || changed) begin
            st_d = ZP_BUSY;
            ic_d = '0;
        end else begin
            unique case (st_q)
                ZP_BUSY: begin
                    if (ic_q == IC_LAST) st_d = ZP_IDLE;
                    else                 ic_d = ic_q + IC_W'(1);
                end
                ZP_IDLE: begin
                    st_d = ZP_IDLE;
                end
                default: begin
                    st_d = ZP_BUSY;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        zp_en = (st_q == ZP_IDLE);
    end

endmodule

// File: rtl/bus_idle_pdn.sv
module bus_idle_pdn
    import bip_pkg::*;
#(
    parameter int IN_W      = 16,
    parameter int CNT_W     = 8,
    parameter int DW        = 8,
    parameter int DEF_LIMIT = 16,
    parameter int IDLE_CYC  = 9,
    parameter int SYNC      = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            strobe,
    input  logic            alt_clk,
    input  logic [IN_W-1:0] sense,
    input  logic            reg_wr,
    input  logic            reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            pdn,
    output logic            standby,
    output logic            zp_en,
    output logic            array_clk_en,
    output logic            macro_clk_en
);

    mode_t            mode;
    logic [CNT_W-1:0] limit;
    logic             tick;
    logic             cfg_apd_en;
    logic             cfg_turbo;

    assign cfg_apd_en = mode.apd_en;
    assign cfg_turbo  = mode.turbo;

    bip_regs #(
        .DW(DW), .CNT_W(CNT_W), .DEF_LIMIT(DEF_LIMIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .mode(mode), .limit(limit), .rdata(reg_rdata)
    );

    bip_tick #(
        .SYNC(SYNC)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .alt_clk(alt_clk),
        .alt_sel(mode.alt_sel), .tick(tick)
    );

    bip_apd #(
        .CNT_W(CNT_W)
    ) u_apd (
        .clk(clk), .rst_n(rst_n), .apd_en(cfg_apd_en), .limit(limit),
        .strobe(strobe), .tick(tick), .pdn(pdn)
    );

    bip_idle #(
        .IN_W(IN_W), .IDLE_CYC(IDLE_CYC)
    ) u_idle (
        .clk(clk), .rst_n(rst_n), .turbo(cfg_turbo),
        .sense(sense), .zp_en(zp_en)
    );

    assign standby      = cs_n | pdn;
    assign array_clk_en = ~mode.array_off;
    assign macro_clk_en = ~mode.macro_off;

endmodule

// File: rtl/bip_checker.sv
module bip_checker #(
    parameter int IN_W  = 16,
    parameter int CNT_W = 8,
    parameter int DW    = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            strobe,
    input logic [IN_W-1:0] sense,
    input logic            reg_wr,
    input logic            reg_addr,
    input logic [DW-1:0]   reg_wdata,
    input logic [DW-1:0]   reg_rdata,
    input logic            pdn,
    input logic            zp_en,
    input logic            apd_en,
    input logic            turbo
);

    AST_EDGE_BLOCKS_PDN: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(strobe) |=> !pdn); // R5

    AST_PDN_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn && !$stable(strobe)) |=> !pdn); // R4

    AST_PDN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pdn) |-> $past(apd_en)); // R3

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !apd_en |=> !pdn); // R3

    AST_TURBO_BLOCKS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        turbo |=> !zp_en); // R7

    AST_WAKE_ON_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sense) |=> ##1 !zp_en); // R7

    AST_LIMIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr) |=>
            (!reg_addr || reg_rdata[CNT_W-1:0] == $past(reg_wdata[CNT_W-1:0]))); // R9

endmodule

bind bus_idle_pdn bip_checker #(.IN_W(IN_W), .CNT_W(CNT_W), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sense(sense),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pdn(pdn), .zp_en(zp_en),
    .apd_en(cfg_apd_en), .turbo(cfg_turbo)
);

// File: tb/bus_idle_pdn_test.sv
module bus_idle_pdn_test;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W       = 16;
    localparam int CNT_W      = 8;
    localparam int DW         = 8;
    localparam int DEF_LIMIT  = 16;
    localparam int IDLE_CYC   = 9;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cs_n = 1'b0;
    logic            strobe = 1'b0;
    logic            alt_clk = 1'b0;
    logic [IN_W-1:0] sense = '0;
    logic            reg_wr = 1'b0;
    logic            reg_addr = 1'b0;
    logic [DW-1:0]   reg_wdata = '0;
    logic [DW-1:0]   reg_rdata;
    logic            pdn, standby, zp_en, array_clk_en, macro_clk_en;

    bus_idle_pdn #(
        .IN_W(IN_W), .CNT_W(CNT_W), .DW(DW), .DEF_LIMIT(DEF_LIMIT),
        .IDLE_CYC(IDLE_CYC), .SYNC(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .strobe(strobe),
        .alt_clk(alt_clk), .sense(sense), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pdn(pdn), .standby(standby), .zp_en(zp_en),
        .array_clk_en(array_clk_en), .macro_clk_en(macro_clk_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    int              m_st;   // 0 off, 1 counting, 2 down
    int              m_cnt;
    int              m_lim;
    int              m_ic;
    logic            m_z, m_strb, m_apd, m_turbo;
    logic [IN_W-1:0] m_in_q, m_in_prev;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [DW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic init_model(input logic [7:0] md, input int lim);
        wr(1'b1, 8'(lim));
        wr(1'b0, 8'h10);
        wr(1'b0, md);
        m_apd = md[0]; m_turbo = md[4];
        m_lim = (lim == 0) ? 1 : lim;
        m_st = 0; m_cnt = 0; m_strb = strobe;
        m_in_q = sense; m_in_prev = sense; m_z = 1'b0; m_ic = 0;
    endtask

    // model of the next rising edge, from R2..R5 and R7
    task automatic model_step(input logic s, input logic [IN_W-1:0] inp);
        logic edge_s, chg;
        edge_s = (s != m_strb);
        m_strb = s;
        if (!m_apd) m_st = 0;
        else if (m_st == 0) begin m_st = 1; m_cnt = m_lim; end
        else if (edge_s) begin m_st = 1; m_cnt = m_lim; end
        else if (m_st == 1) begin
            if (m_cnt <= 1) m_st = 2;
            else m_cnt = m_cnt - 1;
        end
        chg = (m_in_q != m_in_prev);
        m_in_prev = m_in_q;
        m_in_q = inp;
        if (m_turbo || chg) begin m_z = 1'b0; m_ic = 0; end
        else if (!m_z) begin
            if (m_ic == IDLE_CYC - 1) m_z = 1'b1;
            else m_ic = m_ic + 1;
        end
    endtask

    task automatic cyc(input logic s, input logic c, input logic [IN_W-1:0] inp,
                       input string tp);
        strobe = s; cs_n = c; sense = inp;
        model_step(s, inp);
        @(negedge clk);
        check(tp,   "pdn",     pdn,     (m_st == 2));
        check("R1", "standby", standby, c | (m_st == 2));
        check("R7", "zp_en",   zp_en,   m_z);
    endtask

    task automatic rand_phase(input int n, input int p_s, input int p_c,
                              input int p_i, input string tp);
        for (int i = 0; i < n; i++) begin
            logic s, c;
            logic [IN_W-1:0] v;
            s = strobe;
            if ($urandom_range(p_s - 1) == 0) s = ~strobe;
            c = ($urandom_range(p_c - 1) == 0);
            v = sense;
            if (p_i > 0 && $urandom_range(p_i - 1) == 0) v = IN_W'($urandom);
            cyc(s, c, v, tp);
        end
    endtask

    task automatic alt_pulse();
        alt_clk = 1'b1;
        repeat (4) @(negedge clk);
        alt_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h0005EED1));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state, R9 reset values
        check("R10", "pdn after reset", pdn, 1'b0);
        check("R10", "zp_en after reset", zp_en, 1'b0);
        check("R10", "array_clk_en after reset", array_clk_en, 1'b1);
        check("R10", "macro_clk_en after reset", macro_clk_en, 1'b1);
        reg_addr = 1'b0; #1;
        check("R9", "mode reset", reg_rdata, 8'h10);
        reg_addr = 1'b1; #1;
        check("R9", "limit reset", reg_rdata, 8'(DEF_LIMIT));

        // R1 chip select forces standby
        cs_n = 1'b1; #1;
        check("R1", "standby on cs_n", standby, 1'b1);
        cs_n = 1'b0; #1;
        check("R1", "standby released", standby, 1'b0);
        @(negedge clk);

        // R2 random strobe/cs with limit 5
        init_model(8'h11, 5);
        rand_phase(300, 8, 4, 0, "R2");

        // R5 edge exactly on the expiring tick, then R2 full expiry, R4 wake
        cyc(~strobe, 1'b0, sense, "R2");
        for (int i = 0; i < 4; i++) cyc(strobe, 1'b0, sense, "R2");
        cyc(~strobe, 1'b0, sense, "R5");
        check("R5", "pdn held low at collision", pdn, 1'b0);
        for (int i = 0; i < 5; i++) cyc(strobe, 1'b0, sense, "R2");
        check("R2", "pdn after full limit", pdn, 1'b1);
        cyc(~strobe, 1'b0, sense, "R4");
        check("R4", "pdn cleared by edge", pdn, 1'b0);

        // R2 limit 0 acts as 1
        init_model(8'h11, 0);
        cyc(~strobe, 1'b0, sense, "R2");
        cyc(strobe, 1'b0, sense, "R2");
        check("R2", "limit zero expiry", pdn, 1'b1);
        rand_phase(100, 3, 6, 0, "R2");

        // R7 turbo clear, random sense activity
        init_model(8'h01, 3);
        rand_phase(400, 6, 4, 12, "R2");
        for (int i = 0; i < IDLE_CYC + 3; i++) cyc(strobe, 1'b0, sense, "R2");
        check("R7", "zp_en after quiet inputs", zp_en, 1'b1);
        cyc(strobe, 1'b0, ~sense, "R2");
        cyc(strobe, 1'b0, sense, "R2");
        check("R7", "zp_en woken by change", zp_en, 1'b0);

        // R3 disable and re-enable
        init_model(8'h11, 2);
        cyc(~strobe, 1'b0, sense, "R2");
        for (int i = 0; i < 3; i++) cyc(strobe, 1'b0, sense, "R2");
        check("R3", "pdn before disable", pdn, 1'b1);
        wr(1'b0, 8'h10);
        @(negedge clk);
        check("R3", "pdn after disable", pdn, 1'b0);
        wr(1'b0, 8'h11);
        @(negedge clk);
        @(negedge clk);
        check("R3", "pdn one cycle before restart expiry", pdn, 1'b0);
        @(negedge clk);
        check("R3", "pdn at restart expiry", pdn, 1'b1);

        // R6 alternate tick source
        init_model(8'h13, 3);
        strobe = ~strobe;
        repeat (30) @(negedge clk);
        check("R6", "frozen without alt_clk", pdn, 1'b0);
        alt_pulse();
        alt_pulse();
        check("R6", "two alt ticks", pdn, 1'b0);
        alt_pulse();
        check("R6", "third alt tick expires", pdn, 1'b1);
        strobe = ~strobe;
        @(negedge clk);
        check("R4", "wake in alt mode", pdn, 1'b0);

        // R8 clock enables
        wr(1'b0, 8'h14);
        check("R8", "array_clk_en off", array_clk_en, 1'b0);
        check("R8", "macro_clk_en kept", macro_clk_en, 1'b1);
        wr(1'b0, 8'h18);
        check("R8", "array_clk_en kept", array_clk_en, 1'b1);
        check("R8", "macro_clk_en off", macro_clk_en, 1'b0);
        wr(1'b0, 8'h1C);
        check("R8", "both off", {array_clk_en, macro_clk_en}, 2'b00);

        // R9 register readback
        wr(1'b0, 8'hFF);
        reg_addr = 1'b0; #1;
        check("R9", "mode upper bits zero", reg_rdata, 8'h1F);
        wr(1'b1, 8'hA5);
        reg_addr = 1'b1; #1;
        check("R9", "limit readback", reg_rdata, 8'hA5);
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule